// File: doc/BRIEF.md
# Divide Stage Sequencer with Result Interlock

This block tracks a long-latency floating-point divide as it moves through a fixed stage pattern inside an FPU pipeline. A one-cycle issue request carries a precision flag and a 4-bit destination register number. Once accepted, the sequencer advances exactly one step per clock. It reports the current stage as a 3-bit code and a 5-bit position within the pattern. The single-precision pattern has 14 steps. The double-precision pattern has 27 steps. Each pattern starts with a fetch step and a decode step, then runs a block of first-execute steps, then a long run of divide-loop steps, then more first-execute steps, then a second-execute step, and finishes with a store step.

While the divide is in flight, later instructions can query a hazard port. They present up to two source register numbers and one destination register number, each with its own enable. The block answers combinationally whether the instruction must stall. An instruction stalls when any enabled index equals the stored divide destination. It also stalls when it is flagged as an FPU-related CPU operation. All other instructions proceed in parallel with the divide. Only one divide can be in flight at a time, so a second issue request is refused until the current divide has finished.

Top module: `fdiv_stage_seq`

## Requirements
- R1: After synchronous active-high reset, including a reset applied mid-divide, `stage` is IDLE (code 0), `pos` is 0, and `busy`, `done`, `hz_stall` and `issue_stall` are all 0.
- R2: A single-precision issue (`issue_dp`=0) is accepted when not busy. From the next cycle, `pos` counts 0 to 13, one step per clock. The stage codes, in order, are: FETCH(1), DECODE(2), EXEC1(3), DIVLOOP(4) eight times, EXEC1(3), EXEC2(5), STORE(6).
- R3: A double-precision issue (`issue_dp`=1) produces 27 steps, with `pos` counting 0 to 26. The stage codes, in order, are: FETCH, DECODE, EXEC1 twice, DIVLOOP eighteen times, EXEC1 three times, EXEC2, STORE.
- R4: `busy` is 1 from the FETCH step through the STORE step. In the cycle after STORE, `busy` is 0 and `stage` is IDLE.
- R5: `done` is 1 for exactly one cycle, namely the STORE step, and is 0 at every other time.
- R6: While `busy` is 1, `issue_valid` raises `issue_stall` combinationally and the request is ignored. The running pattern continues unchanged, and the stored destination and precision are kept, which the hazard port shows.
- R7: While `busy` is 1, an enabled source index (`chk_src0`, `chk_src1`) equal to the stored destination raises `hz_stall`. A disabled index never does.
- R8: While `busy` is 1, an enabled `chk_dst` equal to the stored destination raises `hz_stall`.
- R9: While `busy` is 1, `chk_fpu_cpu` raises `hz_stall` regardless of the register indices.
- R10: With no matching enabled index and `chk_fpu_cpu` low, `hz_stall` is 0. While `busy` is 0, `hz_stall` is 0 for any input.
- R11: An issue presented during the STORE step is refused. The same request held into the cycle after STORE is accepted, and FETCH follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Divide issue request |
| issue_dp | input | 1 | Precision of issue: 1 = double, 0 = single |
| issue_dst | input | 4 | Destination register number of the divide |
| issue_stall | output | 1 | Issue refused because a divide is in flight |
| stage | output | 3 | Current stage code (0 IDLE, 1 FETCH, 2 DECODE, 3 EXEC1, 4 DIVLOOP, 5 EXEC2, 6 STORE) |
| pos | output | 5 | Step index within the pattern |
| busy | output | 1 | Divide in flight |
| done | output | 1 | One-cycle pulse in the STORE step |
| chk_src0_en | input | 1 | Enable for first source compare |
| chk_src0 | input | 4 | First source register of the querying instruction |
| chk_src1_en | input | 1 | Enable for second source compare |
| chk_src1 | input | 4 | Second source register of the querying instruction |
| chk_dst_en | input | 1 | Enable for destination compare |
| chk_dst | input | 4 | Destination register of the querying instruction |
| chk_fpu_cpu | input | 1 | Querying instruction is an FPU-related CPU operation |
| hz_stall | output | 1 | Querying instruction must wait |

## Verification
The bench builds the block with its default parameters: 4-bit register numbers, a 5-bit position field, and divide-loop runs of 8 and 18 steps. With these values the full double-precision pattern reaches position 26 in a 5-bit field, and each precision's leading and trailing first-execute runs can be told apart. A table of hazard vectors is walked during a double-precision divide, so every compare port, its enable and the forced-stall input is tried against a live destination. Directed cases cover a refused issue in the middle of a run and at the STORE step, back-to-back acceptance, and a reset applied mid-divide.

// File: rtl/fdiv_seq_pkg.sv
package fdiv_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FETCH   = 3'd1,
    ST_DECODE  = 3'd2,
    ST_EXEC1   = 3'd3,
    ST_DIVLOOP = 3'd4,
    ST_EXEC2   = 3'd5,
    ST_STORE   = 3'd6
  } stage_e;
endpackage

// File: rtl/fdiv_stage_map.sv
module fdiv_stage_map
  import fdiv_seq_pkg::*;
#(
  parameter int POS_W    = 5,
  parameter int SP_LEAD  = 1,
  parameter int SP_LOOP  = 8,
  parameter int SP_TRAIL = 1,
  parameter int DP_LEAD  = 2,
  parameter int DP_LOOP  = 18,
  parameter int DP_TRAIL = 3
) (
  input  logic [POS_W-1:0] pos,
  input  logic             dp,
  output stage_e           stage,
  output logic             last
);
  // Step boundaries inside the pattern, for each precision
  localparam int SP_A = 2 + SP_LEAD;
  localparam int SP_B = SP_A + SP_LOOP;
  localparam int SP_C = SP_B + SP_TRAIL;
  localparam int DP_A = 2 + DP_LEAD;
  localparam int DP_B = DP_A + DP_LOOP;
  localparam int DP_C = DP_B + DP_TRAIL;

  int p, a, b, c;

  always_comb begin
    p = int'(pos);
    a = dp ? DP_A : SP_A;
    b = dp ? DP_B : SP_B;
    c = dp ? DP_C : SP_C;
    last = 1'b0;
    if (p == 0)      stage = ST_FETCH;
    else if (p == 1) stage = ST_DECODE;
    else if (p < a)  stage = ST_EXEC1;
    else if (p < b)  stage = ST_DIVLOOP;
    else if (p < c)  stage = ST_EXEC1;
    else if (p == c) stage = ST_EXEC2;
    else begin
      stage = ST_STORE;
      last  = 1'b1;
    end
  end
endmodule

// File: rtl/fdiv_seq_ctrl.sv
module fdiv_seq_ctrl
  import fdiv_seq_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int POS_W    = 5,
  parameter int SP_LEAD  = 1,
  parameter int SP_LOOP  = 8,
  parameter int SP_TRAIL = 1,
  parameter int DP_LEAD  = 2,
  parameter int DP_LOOP  = 18,
  parameter int DP_TRAIL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic             issue_dp,
  input  logic [REG_W-1:0] issue_dst,
  output logic             issue_stall,
  output stage_e           stage_q,
  output logic [POS_W-1:0] pos_q,
  output logic             busy_q,
  output logic             last_q,
  output logic [REG_W-1:0] dst_q
);
  localparam int SP_LEN = 4 + SP_LEAD + SP_LOOP + SP_TRAIL;
  localparam int DP_LEN = 4 + DP_LEAD + DP_LOOP + DP_TRAIL;

  logic             dp_q, dp_d, busy_d, accept, map_last;
  logic [POS_W-1:0] pos_d;
  logic [REG_W-1:0] dst_d;
  stage_e           map_stage;

  assign accept      = issue_valid & ~busy_q;
  assign issue_stall = issue_valid & busy_q;

  always_comb begin
    busy_d = busy_q;
    pos_d  = pos_q;
    dp_d   = dp_q;
    dst_d  = dst_q;
    if (accept) begin
      busy_d = 1'b1;
      pos_d  = '0;
      dp_d   = issue_dp;
      dst_d  = issue_dst;
    end else if (busy_q) begin
      if (last_q) begin
        busy_d = 1'b0;
        pos_d  = '0;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  fdiv_stage_map #(
    .POS_W(POS_W), .SP_LEAD(SP_LEAD), .SP_LOOP(SP_LOOP), .SP_TRAIL(SP_TRAIL),
    .DP_LEAD(DP_LEAD), .DP_LOOP(DP_LOOP), .DP_TRAIL(DP_TRAIL)
  ) map_i (
    .pos   (pos_d),
    .dp    (dp_d),
    .stage (map_stage),
    .last  (map_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pos_q   <= '0;
      dp_q    <= 1'b0;
      dst_q   <= '0;
      stage_q <= ST_IDLE;
      last_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      pos_q   <= pos_d;
      dp_q    <= dp_d;
      dst_q   <= dst_d;
      stage_q <= busy_d ? map_stage : ST_IDLE;
      last_q  <= busy_d & map_last;
    end
  end

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !last_q |=> pos_q == POS_W'($past(pos_q) + 1'b1));
  // R2
  sp_len_chk: assert property (@(posedge clk) disable iff (rst)
    last_q && !dp_q |-> pos_q == POS_W'(SP_LEN - 1));
  // R3
  dp_len_chk: assert property (@(posedge clk) disable iff (rst)
    last_q && dp_q |-> pos_q == POS_W'(DP_LEN - 1));
  // R4
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    last_q |=> !busy_q && stage_q == ST_IDLE);
  // R5
  done_store_chk: assert property (@(posedge clk) disable iff (rst)
    last_q |-> stage_q == ST_STORE);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    last_q |=> !last_q);
  // R6
  dst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !last_q |=> $stable(dst_q) && $stable(dp_q));
endmodule

// File: rtl/fdiv_hazard.sv
module fdiv_hazard #(
  parameter int REG_W  = 4,
  parameter int N_CMP  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [REG_W-1:0] div_dst,
  input  logic [N_CMP-1:0] cmp_en,
  input  logic [REG_W-1:0] cmp_idx [N_CMP],
  input  logic             fpu_cpu,
  output logic             stall
);
  logic [N_CMP-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < N_CMP; g++) begin : g_cmp
      assign hit[g] = cmp_en[g] && (cmp_idx[g] == div_dst);
    end
  endgenerate

  assign stall = busy && ((|hit) || fpu_cpu);

  // R10
  idle_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !stall);
  // R9
  cpu_force_chk: assert property (@(posedge clk) disable iff (rst)
    busy && fpu_cpu |-> stall);
endmodule

// File: rtl/fdiv_stage_seq.sv
module fdiv_stage_seq
  import fdiv_seq_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int POS_W    = 5,
  parameter int SP_LEAD  = 1,
  parameter int SP_LOOP  = 8,
  parameter int SP_TRAIL = 1,
  parameter int DP_LEAD  = 2,
  parameter int DP_LOOP  = 18,
  parameter int DP_TRAIL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic             issue_dp,
  input  logic [REG_W-1:0] issue_dst,
  output logic             issue_stall,
  output logic [2:0]       stage,
  output logic [POS_W-1:0] pos,
  output logic             busy,
  output logic             done,
  input  logic             chk_src0_en,
  input  logic [REG_W-1:0] chk_src0,
  input  logic             chk_src1_en,
  input  logic [REG_W-1:0] chk_src1,
  input  logic             chk_dst_en,
  input  logic [REG_W-1:0] chk_dst,
  input  logic             chk_fpu_cpu,
  output logic             hz_stall
);
  localparam int N_CMP = 3;

  stage_e           stage_s;
  logic [REG_W-1:0] div_dst;
  logic [REG_W-1:0] cmp_idx [N_CMP];
  logic [N_CMP-1:0] cmp_en;

  assign cmp_idx[0] = chk_src0;
  assign cmp_idx[1] = chk_src1;
  assign cmp_idx[2] = chk_dst;
  assign cmp_en     = {chk_dst_en, chk_src1_en, chk_src0_en};
  assign stage      = stage_s;

  fdiv_seq_ctrl #(
    .REG_W(REG_W), .POS_W(POS_W), .SP_LEAD(SP_LEAD), .SP_LOOP(SP_LOOP),
    .SP_TRAIL(SP_TRAIL), .DP_LEAD(DP_LEAD), .DP_LOOP(DP_LOOP), .DP_TRAIL(DP_TRAIL)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_dp    (issue_dp),
    .issue_dst   (issue_dst),
    .issue_stall (issue_stall),
    .stage_q     (stage_s),
    .pos_q       (pos),
    .busy_q      (busy),
    .last_q      (done),
    .dst_q       (div_dst)
  );

  fdiv_hazard #(.REG_W(REG_W), .N_CMP(N_CMP)) hz_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .div_dst (div_dst),
    .cmp_en  (cmp_en),
    .cmp_idx (cmp_idx),
    .fpu_cpu (chk_fpu_cpu),
    .stall   (hz_stall)
  );

  // R11
  accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && issue_valid |=> busy && stage == 3'd1 && pos == '0);
  // R6
  refuse_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !done && issue_valid |=> busy && pos != '0);
endmodule

// File: tb/fdiv_stage_seq_tb_top.sv
`timescale 1ns/1ps
module fdiv_stage_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_valid = 0, issue_dp = 0;
  logic [3:0] issue_dst = 0;
  logic issue_stall, busy, done, hz_stall;
  logic [2:0] stage;
  logic [4:0] pos;
  logic s0en = 0, s1en = 0, den = 0, cpu = 0;
  logic [3:0] s0 = 0, s1 = 0, d = 0;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  fdiv_stage_seq dut_i (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_dp(issue_dp),
    .issue_dst(issue_dst), .issue_stall(issue_stall), .stage(stage), .pos(pos),
    .busy(busy), .done(done), .chk_src0_en(s0en), .chk_src0(s0),
    .chk_src1_en(s1en), .chk_src1(s1), .chk_dst_en(den), .chk_dst(d),
    .chk_fpu_cpu(cpu), .hz_stall(hz_stall)
  );

  // Hazard vectors, divide destination is 5:
  // {req, s0en, s0, s1en, s1, den, d, cpu, expected stall}
  localparam logic [20:0] HZ [8] = '{
    {4'd10, 1'b0, 4'd5, 1'b0, 4'd5, 1'b0, 4'd5, 1'b0, 1'b0},
    {4'd7,  1'b1, 4'd5, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1},
    {4'd10, 1'b1, 4'd4, 1'b1, 4'd6, 1'b1, 4'd7, 1'b0, 1'b0},
    {4'd7,  1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 4'd0, 1'b0, 1'b1},
    {4'd8,  1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 1'b1},
    {4'd7,  1'b0, 4'd5, 1'b1, 4'd6, 1'b1, 4'd7, 1'b0, 1'b0},
    {4'd9,  1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1},
    {4'd8,  1'b1, 4'd3, 1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected stage code from the requirement text (R2, R3)
  function automatic int exp_stage(input bit dpm, input int i);
    int lead, loopn, trail, len;
    lead = dpm ? 2 : 1; loopn = dpm ? 18 : 8; trail = dpm ? 3 : 1;
    len = 4 + lead + loopn + trail;
    if (i == 0) return 1;
    if (i == 1) return 2;
    if (i == len - 1) return 6;
    if (i == len - 2) return 5;
    if (i < 2 + lead || i >= 2 + lead + loopn) return 3;
    return 4;
  endfunction

  task automatic clr_hz();
    s0en = 0; s1en = 0; den = 0; cpu = 0; s0 = 0; s1 = 0; d = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check("R1 stage", stage, 0); check("R1 pos", pos, 0);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    cpu = 1; issue_valid = 0; #0.1;
    check("R10 idle stall", hz_stall, 0);
    cpu = 0;

    // Single-precision divide to register 5
    @(negedge clk); issue_valid = 1; issue_dp = 0; issue_dst = 5;
    @(negedge clk); issue_valid = 0;
    for (int i = 0; i < 14; i++) begin
      if (i == 6) issue_valid = 0;
      #1;
      check("R2 stage", stage, exp_stage(0, i));
      check("R2 pos", pos, i);
      check("R4 busy", busy, 1);
      check("R5 done", done, (i == 13));
      if (i == 5) begin
        issue_valid = 1; issue_dp = 1; issue_dst = 9; #0.1;
        check("R6 issue_stall", issue_stall, 1);
      end
      if (i == 7) begin
        s0en = 1; s0 = 9; #0.1;
        check("R6 ignored dst not stored", hz_stall, 0);
        s0 = 5; #0.1;
        check("R6 stored dst kept", hz_stall, 1);
        clr_hz();
      end
      if (i == 13) begin
        issue_valid = 1; issue_dp = 1; issue_dst = 5; #0.1;
        check("R11 refused in store", issue_stall, 1);
      end
      @(negedge clk);
    end
    #1;
    check("R4 idle after store", busy, 0);
    check("R4 stage idle", stage, 0);
    check("R5 done low", done, 0);
    check("R11 accept idle", issue_stall, 0);
    @(negedge clk); issue_valid = 0;

    // Double-precision divide, hazard table walked during run
    for (int i = 0; i < 27; i++) begin
      #1;
      check("R3 stage", stage, exp_stage(1, i));
      check("R3 pos", pos, i);
      check("R4 busy", busy, 1);
      check("R5 done", done, (i == 26));
      if (i >= 2 && i < 10) begin
        logic [20:0] v;
        v = HZ[i-2];
        s0en = v[16]; s0 = v[15:12]; s1en = v[11]; s1 = v[10:7];
        den = v[6]; d = v[5:2]; cpu = v[1]; #0.1;
        check($sformatf("R%0d hazard vec %0d (R7 R8 R9 R10)", v[20:17], i-2),
              hz_stall, v[0]);
        clr_hz();
      end
      @(negedge clk);
    end
    #1;
    check("R4 idle after dp", busy, 0);
    s0en = 1; s0 = 5; den = 1; d = 5; cpu = 1; #0.1;
    check("R10 idle no stall", hz_stall, 0);
    clr_hz();

    // Reset mid-divide
    @(negedge clk); issue_valid = 1; issue_dp = 1; issue_dst = 5;
    @(negedge clk); issue_valid = 0;
    repeat (4) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0; #1;
    check("R1 mid reset stage", stage, 0);
    check("R1 mid reset pos", pos, 0);
    check("R1 mid reset busy", busy, 0);
    check("R1 mid reset done", done, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule